// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block tracks the single reservation of one hart for load-reserved / store-conditional pairs. Each load-reserved strobe captures the granule that holds its address and arms the reservation. Each store-conditional strobe is answered in the same cycle. The answer is success only when the reservation is armed and the store's address falls in the same granule. Once a store-conditional has been answered, the reservation is always dropped.

Three other events disarm the reservation. The first is a trap or exception-return event from the core. The second is an active-low invalidate line. That line may change at any time with respect to the clock, so it passes through a synchronizer before it acts. The granule size is a parameter. The armed granule base is shown on a status output, and that output reads all-ones while nothing is armed.

Top module: `resv_monitor`

## Requirements
- R1: After reset no reservation is armed: `resv_addr` reads all-ones and `sc_ok` is low.
- R2: A load-reserved strobe arms the reservation at the next rising edge. From that edge on, `resv_addr` shows `lr_addr` with its low log2(GRAN_BYTES) bits forced to zero.
- R3: A store-conditional strobe reports `sc_ok` high in the same cycle when a reservation is armed and `sc_addr` matches the recorded address in every bit above the low log2(GRAN_BYTES) bits. The low bits are ignored in this comparison.
- R4: A store-conditional whose address lies in a different granule from the armed one reports `sc_ok` low.
- R5: A store-conditional with no reservation armed reports `sc_ok` low. `sc_ok` is never high in a cycle without a store-conditional strobe.
- R6: After any store-conditional, successful or not, the reservation is disarmed at the next edge unless a load-reserved strobe occurs in the same cycle.
- R7: `inval_n` passes through SYNC_STAGES flops. If it is sampled low at edge k, the reservation is disarmed at edge k+SYNC_STAGES. With the default of 2 stages, that is the third edge, counting edge k as the first.
- R8: A trap or exception-return event (`trap_evt` high) disarms the reservation at the next edge.
- R9: A load-reserved strobe takes precedence over every disarming event that acts at the same edge (a trap, a store-conditional, or a synchronized invalidate). The result is a freshly armed reservation at the new address.
- R10: A second load-reserved strobe before any store-conditional replaces the recorded granule.
- R11: When a store-conditional and a load-reserved strobe share a cycle, `sc_ok` is judged against the old reservation, and the new address is armed afterwards.
- R12: The granule boundary follows GRAN_BYTES (default 64). Addresses differing only below bit log2(GRAN_BYTES) match. Addresses differing at that bit do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_fire | input | 1 | Load-reserved executes this cycle |
| lr_addr | input | ADDR_W | Load-reserved address |
| sc_fire | input | 1 | Store-conditional executes this cycle |
| sc_addr | input | ADDR_W | Store-conditional address |
| sc_ok | output | 1 | Same-cycle store-conditional success |
| inval_n | input | 1 | Active-low invalidate, asynchronous to clk |
| trap_evt | input | 1 | Trap taken or exception return executed |
| resv_addr | output | ADDR_W | Armed granule base, all-ones when idle |

## Verification
The bench targets the cases where two events meet in one cycle. The first is a load-reserved together with a trap, a store-conditional or a synchronized invalidate. A design with the wrong precedence would drop the fresh reservation. The second is a store-conditional together with a new load-reserved. A design that compared against the new address would wrongly succeed or fail.

It also probes the granule boundary from both sides. An off-by-one in the ignored bit count would either accept a store one granule away or reject one inside the granule. It also counts the exact synchronizer latency of the invalidate line. A design with a stage too few or too many would clear the reservation a cycle early or late. Finally, it checks that the reservation is disarmed after failed stores, since a design that only cleared on success would let a later store succeed.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Number of address bits inside one reservation granule.
  function automatic int unsigned gran_shift(input int unsigned gran_bytes);
    return $clog2(gran_bytes);
  endfunction

  // Next-state selection of the reservation register.
  typedef enum logic [1:0] {
    RS_HOLD  = 2'd0,
    RS_ARM   = 2'd1,
    RS_CLEAR = 2'd2
  } resv_op_e;

endpackage

// File: rtl/resv_inval_sync.sv
module resv_inval_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inval_n,
  output logic kill
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = inval_n;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], inval_n};
    end
  endgenerate

  // Reset to the inactive (high) level so no clear is seen on release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign kill = ~sh_q[STAGES-1];

endmodule

// File: rtl/resv_tag_match.sv
module resv_tag_match #(
  parameter int TAG_W = 34
) (
  input  logic [TAG_W-1:0] held_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit
);

  assign hit = (held_tag == probe_tag);

endmodule

// File: rtl/resv_state.sv
module resv_state
  import resv_pkg::*;
#(
  parameter int TAG_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TAG_W-1:0] arm_tag,
  input  logic             clear,
  output logic             valid_q,
  output logic [TAG_W-1:0] tag_q
);

  resv_op_e   op;
  logic       valid_d;
  logic       tag_en;

  // Arm wins over every clearing source that lands on the same edge.
  always_comb begin
    if (arm)        op = RS_ARM;
    else if (clear) op = RS_CLEAR;
    else            op = RS_HOLD;
  end

  always_comb begin
    valid_d = valid_q;
    tag_en  = 1'b0;
    unique case (op)
      RS_ARM: begin
        valid_d = 1'b1;
        tag_en  = 1'b1;
      end
      RS_CLEAR: valid_d = 1'b0;
      default:  valid_d = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= arm_tag;
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int GRAN_BYTES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_fire,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic              sc_fire,
  input  logic [ADDR_W-1:0] sc_addr,
  output logic              sc_ok,
  input  logic              inval_n,
  input  logic              trap_evt,
  output logic [ADDR_W-1:0] resv_addr
);

  localparam int OFS_W = int'(gran_shift(GRAN_BYTES));
  localparam int TAG_W = ADDR_W - OFS_W;

  logic             kill;
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] lr_tag;
  logic [TAG_W-1:0] sc_tag;
  logic             hit;
  logic             clr;

  assign lr_tag = TAG_W'(lr_addr >> OFS_W);
  assign sc_tag = TAG_W'(sc_addr >> OFS_W);

  resv_inval_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .inval_n (inval_n),
    .kill    (kill)
  );

  resv_tag_match #(.TAG_W(TAG_W)) u_match (
    .held_tag  (tag_q),
    .probe_tag (sc_tag),
    .hit       (hit)
  );

  assign clr = sc_fire | trap_evt | kill;

  resv_state #(.TAG_W(TAG_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (lr_fire),
    .arm_tag (lr_tag),
    .clear   (clr),
    .valid_q (valid_q),
    .tag_q   (tag_q)
  );

  // Judged on the registered reservation, before any same-cycle LR.
  assign sc_ok     = sc_fire & valid_q & hit;
  assign resv_addr = valid_q ? {tag_q, {OFS_W{1'b0}}} : '1;

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int ADDR_W = 40,
  parameter int OFS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lr_fire,
  input logic [ADDR_W-1:0] lr_addr,
  input logic              sc_fire,
  input logic [ADDR_W-1:0] sc_addr,
  input logic              sc_ok,
  input logic              trap_evt,
  input logic [ADDR_W-1:0] resv_addr
);

  logic idle;
  logic same_gran;
  assign idle      = (resv_addr == '1);
  assign same_gran = (resv_addr[ADDR_W-1:OFS_W] == sc_addr[ADDR_W-1:OFS_W]);

  // R5
  a_r5_ok_needs_sc: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_fire || idle) |-> !sc_ok);

  // R3
  a_r3_match_succeeds: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !idle && same_gran) |-> sc_ok);

  // R4
  a_r4_mismatch_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !same_gran) |-> !sc_ok);

  // R2
  a_r2_lr_records: assert property (@(posedge clk) disable iff (!rst_n)
    lr_fire |=> (resv_addr[ADDR_W-1:OFS_W] == $past(lr_addr[ADDR_W-1:OFS_W]))
                && (resv_addr[OFS_W-1:0] == '0));

  // R6
  a_r6_sc_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !lr_fire) |=> (resv_addr == '1));

  // R8
  a_r8_trap_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_evt && !lr_fire) |=> (resv_addr == '1));

  // R10
  a_r10_only_lr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!lr_fire && !idle) |=> ((resv_addr == '1) || $stable(resv_addr)));

endmodule

bind resv_monitor resv_monitor_chk #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lr_fire   (lr_fire),
  .lr_addr   (lr_addr),
  .sc_fire   (sc_fire),
  .sc_addr   (sc_addr),
  .sc_ok     (sc_ok),
  .trap_evt  (trap_evt),
  .resv_addr (resv_addr)
);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;

  localparam int AW   = 40;
  localparam int GRAN = 64;
  localparam int SYN  = 2;
  localparam int OFS  = $clog2(GRAN);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lr_fire, sc_fire, inval_n, trap_evt;
  logic [AW-1:0] lr_addr, sc_addr;
  logic          sc_ok;
  logic [AW-1:0] resv_addr;

  int n_chk = 0;
  int n_bad = 0;

  // Behavioural reference state.
  bit          m_valid;
  logic [AW-1:0] m_addr;
  bit          pipe[$];

  always #4 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .GRAN_BYTES(GRAN), .SYNC_STAGES(SYN)) dut (
    .clk(clk), .rst_n(rst_n),
    .lr_fire(lr_fire), .lr_addr(lr_addr),
    .sc_fire(sc_fire), .sc_addr(sc_addr), .sc_ok(sc_ok),
    .inval_n(inval_n), .trap_evt(trap_evt), .resv_addr(resv_addr)
  );

  function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a);
    return (a >> OFS) << OFS;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input bit lr, input logic [AW-1:0] la,
                      input bit sc, input logic [AW-1:0] sa,
                      input bit inv_n, input bit trp);
    logic exp_ok;
    logic [AW-1:0] exp_addr;
    bit kill;
    lr_fire = lr; lr_addr = la; sc_fire = sc; sc_addr = sa;
    inval_n = inv_n; trap_evt = trp;
    #1;
    exp_ok   = sc && m_valid && (base_of(sa) == base_of(m_addr));
    exp_addr = m_valid ? base_of(m_addr) : '1;
    check(req, "sc_ok", AW'(sc_ok), AW'(exp_ok));
    check(req, "resv_addr", resv_addr, exp_addr);
    @(posedge clk);
    kill = (pipe[$] == 1'b0);
    pipe.push_front(inv_n);
    void'(pipe.pop_back());
    if (lr) begin
      m_valid = 1'b1;
      m_addr  = la;
    end else if (sc || trp || kill) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    step(req, 0, '0, 0, '0, 1, 0);
  endtask

  localparam logic [AW-1:0] A = 40'h80_0000_1234;
  localparam logic [AW-1:0] B = 40'h80_0000_2010;
  localparam logic [AW-1:0] C = 40'h80_0000_3100;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0;
    lr_fire = 0; sc_fire = 0; trap_evt = 0; inval_n = 1;
    lr_addr = '0; sc_addr = '0;
    m_valid = 0; m_addr = '0;
    for (int i = 0; i < SYN; i++) pipe.push_back(1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step("R1", 0, '0, 1, A, 1, 0);          // reset state, SC fails (R5)
    step("R2", 1, A, 0, '0, 1, 0);
    idle("R2");
    step("R3", 0, '0, 1, A + 40'h0B, 1, 0); // same granule, low bits differ
    idle("R6");
    step("R4", 1, A, 0, '0, 1, 0);
    step("R4", 0, '0, 1, A + 40'h40, 1, 0);
    idle("R6");
    step("R5", 0, '0, 1, A, 1, 0);
    // R7: invalidate latency through the synchronizer
    step("R7", 1, B, 0, '0, 1, 0);
    step("R7", 0, '0, 0, '0, 0, 0);
    idle("R7");
    idle("R7");
    idle("R7");
    // R8
    step("R8", 1, A, 0, '0, 1, 0);
    step("R8", 0, '0, 0, '0, 1, 1);
    idle("R8");
    // R9: LR against trap, then against synchronized invalidate
    step("R9", 1, B, 0, '0, 1, 0);
    step("R9", 1, C, 0, '0, 1, 1);
    idle("R9");
    step("R9", 0, '0, 0, '0, 0, 0);
    idle("R9");
    step("R9", 1, A, 0, '0, 1, 0);
    idle("R9");
    step("R9", 1, C, 1, A, 1, 0);
    idle("R9");
    // R10
    step("R10", 1, A, 0, '0, 1, 0);
    step("R10", 1, B, 0, '0, 1, 0);
    step("R10", 0, '0, 1, A, 1, 0);
    // R11
    step("R11", 1, A, 0, '0, 1, 0);
    step("R11", 1, B, 1, A, 1, 0);
    step("R11", 0, '0, 1, B, 1, 0);
    // R12: granule edges
    step("R12", 1, 40'h80_0000_013F, 0, '0, 1, 0);
    step("R12", 0, '0, 1, 40'h80_0000_0100, 1, 0);
    step("R12", 1, 40'h80_0000_013F, 0, '0, 1, 0);
    step("R12", 0, '0, 1, 40'h80_0000_0140, 1, 0);
    step("R12", 1, 40'h80_0000_0140, 0, '0, 1, 0);
    step("R12", 0, '0, 1, 40'h80_0000_013F, 1, 0);

    // Mixed traffic over a few nearby granules.
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] la, sa;
      la = 40'h80_0000_1000 + AW'(($urandom % 6) * 24);
      sa = 40'h80_0000_1000 + AW'(($urandom % 6) * 24);
      step("R2", ($urandom % 3) == 0, la, ($urandom % 3) == 0, sa,
           ($urandom % 8) != 0, ($urandom % 10) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule